// File: doc/BRIEF.md
# RLE sample slice decompressor

This block turns the raw contents of a logic analyzer's capture memory back into a stream of 34-channel samples. Capture memory is read out as 32-bit words grouped in slices of nine. The first eight words of a slice hold the low 32 bits of eight 36-bit entries. The ninth word packs the four high bits of all eight entries. The block gathers a slice, rebuilds the eight entries and run-length decodes them into samples, each repeated as often as its run says.

An entry read in the data state carries a 34-bit sample value, a bit that adds one extra repeat, and a bit that marks the following entry as a length word. A length word adds twice its value to the run of the sample before it. A programmable limit caps the number of samples emitted. Once the limit is reached, the remaining entries are consumed and dropped. A one-cycle start pulse begins a new capture from a clean state.

Both data interfaces are valid/ready. An input word is taken on a cycle where in_valid and in_ready are both high. A sample is delivered on a cycle where out_valid and out_ready are both high. While out_ready is low the sample on out_sample is held unchanged. The block lowers in_ready while it is still working through a gathered slice or expanding a run. The source may hold in_valid high and wait.

Top module: `rle_slice_decomp`

## Requirements
- R1: Entry i of a slice (i = 0 to 7) takes its low 32 bits from input word i and its bits [35:32] from bits [31-4i : 28-4i] of the ninth word. Entry 0 therefore uses the top nibble of the ninth word. Entries are decoded in order 0 to 7.
- R2: An entry decoded in the data state emits its bits [33:0] as the sample value. The sample is emitted bit 34 plus one times, so once or twice.
- R3: When bit 35 of a data entry is set, the next entry is a length word. The length word adds twice its full 36-bit value to the repeat count of the current sample, and decoding then returns to the data state. When bit 35 is clear, the next entry is again a data entry. This holds across slice boundaries.
- R4: One sample is delivered per cycle where out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_valid stays high and out_sample does not change.
- R5: After sample_limit samples have been delivered since the last start pulse, out_valid stays low until the next start. Later entries, including an unfinished run, are still accepted and discarded. A limit of 0 delivers nothing.
- R6: in_ready is low while out_valid is high. in_ready is also low while the entries of a gathered slice are being decoded.
- R7: A start pulse clears the decode state to the data state and clears the pending run and the delivered-sample count. It also discards a partly gathered slice. During the start cycle, in_ready and out_valid are both low. In the following cycle out_valid is low.
- R8: After reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a new capture |
| sample_limit | input | 32 | Maximum number of samples to deliver after start |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_data | input | 32 | Capture memory word |
| out_valid | output | 1 | A decoded sample is offered |
| out_ready | input | 1 | Sink takes the offered sample |
| out_sample | output | 34 | Decoded 34-channel sample value |

## Verification
A start pulse can land in the same cycle as a sample handshake that would otherwise happen, or while a slice is only partly gathered. The bench provokes the first case by pulsing start in the middle of a 41-sample run with out_ready held high. It provokes the second by pulsing start after only four words of a slice have been sent. In both cases the start must win. No sample may appear after the pulse until new data arrives. The next stream must decode from the data state with a fresh count, which the per-clock reference model judges.

// File: rtl/rle_slice_pkg.sv
package rle_slice_pkg;
  typedef enum logic {
    RD_DATA = 1'b0,
    RD_LEN  = 1'b1
  } rle_state_e;
endpackage

// File: rtl/rle_slice_gather.sv
module rle_slice_gather #(
  parameter int WORD_W  = 32,
  parameter int ENTRIES = 8,
  localparam int NIB_W   = WORD_W / ENTRIES,
  localparam int ENTRY_W = WORD_W + NIB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               accept_en,
  output logic               in_ready,
  output logic               ent_valid,
  output logic [ENTRY_W-1:0] ent_data,
  input  logic               ent_ready
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int POS_W = $clog2(ENTRIES + 1);

  logic [WORD_W-1:0] low_q [ENTRIES];
  logic [NIB_W-1:0]  lane_nib [ENTRIES];
  logic [WORD_W-1:0] nib_q;
  logic [POS_W-1:0]  pos_q;
  logic [IDX_W-1:0]  idx_q;
  logic              drain_q;
  logic              in_hs;
  logic              ent_hs;
  logic              nib_slot;

  assign in_ready  = !drain_q && accept_en && !clear;
  assign ent_valid = drain_q && !clear;
  assign in_hs     = in_valid && in_ready;
  assign ent_hs    = ent_valid && ent_ready;
  assign nib_slot  = (pos_q == POS_W'(ENTRIES));

  // one storage lane per data word; entry g reads its nibble from the top down
  for (genvar g = 0; g < ENTRIES; g++) begin : g_lane
    assign lane_nib[g] = nib_q[WORD_W-1-NIB_W*g -: NIB_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        low_q[g] <= '0;
      end else if (in_hs && (pos_q == POS_W'(g))) begin
        low_q[g] <= in_data;
      end
    end
  end

  assign ent_data = {lane_nib[idx_q], low_q[idx_q]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q   <= '0;
      pos_q   <= '0;
      idx_q   <= '0;
      drain_q <= 1'b0;
    end else if (clear) begin
      pos_q   <= '0;
      idx_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      if (in_hs) begin
        if (nib_slot) begin
          nib_q   <= in_data;
          pos_q   <= '0;
          idx_q   <= '0;
          drain_q <= 1'b1;
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end
      if (ent_hs) begin
        if (idx_q == IDX_W'(ENTRIES - 1)) begin
          drain_q <= 1'b0;
        end
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/rle_run_expand.sv
module rle_run_expand
  import rle_slice_pkg::*;
#(
  parameter int SAMPLE_W = 34,
  parameter int LIMIT_W  = 32,
  localparam int ENTRY_W = SAMPLE_W + 2,
  localparam int RUN_W   = ENTRY_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                ent_valid,
  input  logic [ENTRY_W-1:0]  ent_data,
  output logic                ent_ready,
  output logic                idle,
  input  logic [LIMIT_W-1:0]  sample_limit,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample
);
  localparam int EXTRA_BIT  = SAMPLE_W;
  localparam int FOLLOW_BIT = SAMPLE_W + 1;

  rle_state_e          state_q;
  logic [SAMPLE_W-1:0] sample_q;
  logic [RUN_W-1:0]    run_q;
  logic [LIMIT_W-1:0]  sent_q;
  logic                limit_hit;
  logic                run_zero;

  assign limit_hit  = (sent_q >= sample_limit);
  assign run_zero   = (run_q == '0);
  assign idle       = run_zero || limit_hit;
  assign ent_ready  = idle && !clear;
  assign out_valid  = !run_zero && !limit_hit && !clear;
  assign out_sample = sample_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RD_DATA;
      sample_q <= '0;
      run_q    <= '0;
      sent_q   <= '0;
    end else if (clear) begin
      state_q  <= RD_DATA;
      sample_q <= '0;
      run_q    <= '0;
      sent_q   <= '0;
    end else begin
      if (out_valid && out_ready) begin
        run_q  <= run_q - RUN_W'(1);
        sent_q <= sent_q + LIMIT_W'(1);
      end
      if (ent_valid && ent_ready) begin
        if (state_q == RD_DATA) begin
          sample_q <= ent_data[SAMPLE_W-1:0];
          run_q    <= RUN_W'(ent_data[EXTRA_BIT]) + RUN_W'(1);
          state_q  <= ent_data[FOLLOW_BIT] ? RD_LEN : RD_DATA;
        end else begin
          run_q   <= run_q + {1'b0, ent_data, 1'b0};
          state_q <= RD_DATA;
        end
      end
    end
  end
endmodule

// File: rtl/rle_slice_decomp.sv
module rle_slice_decomp #(
  parameter int WORD_W  = 32,
  parameter int ENTRIES = 8,
  parameter int LIMIT_W = 32,
  localparam int ENTRY_W  = WORD_W + WORD_W / ENTRIES,
  localparam int SAMPLE_W = ENTRY_W - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LIMIT_W-1:0]  sample_limit,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample
);
  logic               ent_valid;
  logic               ent_ready;
  logic [ENTRY_W-1:0] ent_data;
  logic               dec_idle;

  rle_slice_gather #(
    .WORD_W  (WORD_W),
    .ENTRIES (ENTRIES)
  ) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .accept_en (dec_idle),
    .in_ready  (in_ready),
    .ent_valid (ent_valid),
    .ent_data  (ent_data),
    .ent_ready (ent_ready)
  );

  rle_run_expand #(
    .SAMPLE_W (SAMPLE_W),
    .LIMIT_W  (LIMIT_W)
  ) u_expand (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (start),
    .ent_valid    (ent_valid),
    .ent_data     (ent_data),
    .ent_ready    (ent_ready),
    .idle         (dec_idle),
    .sample_limit (sample_limit),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_sample   (out_sample)
  );
endmodule

// File: rtl/rle_slice_decomp_chk.sv
module rle_slice_decomp_chk #(
  parameter int SAMPLE_W = 34,
  parameter int LIMIT_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [LIMIT_W-1:0]  sample_limit,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_sample
);
  logic [LIMIT_W:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (start) begin
      seen_q <= '0;
    end else if (out_valid && out_ready) begin
      seen_q <= seen_q + (LIMIT_W+1)'(1);
    end
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (start || (out_valid && $stable(out_sample))));

  // R5
  limit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen_q < {1'b0, sample_limit}));

  // R6
  busy_no_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!in_ready && !out_valid));

  // R7
  start_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);
endmodule

bind rle_slice_decomp rle_slice_decomp_chk #(
  .SAMPLE_W (SAMPLE_W),
  .LIMIT_W  (LIMIT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .sample_limit (sample_limit),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_sample   (out_sample)
);

// File: tb/rle_slice_decomp_tb.sv
`timescale 1ns/1ps
module rle_slice_decomp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] sample_limit = 32'hFFFF_FFFF;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [33:0] out_sample;

  always #2 clk = ~clk;

  rle_slice_decomp u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .sample_limit (sample_limit),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_sample (out_sample)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [33:0] exp_q[$];
  int          m_state = 0;
  logic [33:0] m_sample = '0;
  longint unsigned m_emitted = 0;
  longint unsigned m_limit = 64'hFFFF_FFFF;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic emit(input longint unsigned n);
    longint unsigned left = n;
    while (left > 0 && m_emitted < m_limit) begin
      exp_q.push_back(m_sample);
      m_emitted++;
      left--;
    end
  endtask

  // behavioural decode of one entry, following R2 and R3
  task automatic model_entry(input logic [35:0] e);
    if (m_state == 0) begin
      m_sample = e[33:0];
      emit(longint'(e[34]) + 1);
      m_state = e[35] ? 1 : 0;
    end else begin
      emit({28'd0, e} * 2);
      m_state = 0;
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  // packs entries into slices as R1 describes, then sends them
  task automatic send_entries(input logic [35:0] e[$]);
    for (int i = 0; i < e.size(); i++) model_entry(e[i]);
    for (int s = 0; s < e.size() / 8; s++) begin
      logic [31:0] nib = '0;
      for (int i = 0; i < 8; i++) begin
        nib[31-4*i -: 4] = e[8*s+i][35:32];
        send_word(e[8*s+i][31:0]);
      end
      send_word(nib);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_start(input logic [31:0] lim);
    @(negedge clk);
    start = 1'b1;
    sample_limit = lim;
    exp_q.delete();
    m_state = 0;
    m_emitted = 0;
    m_limit = lim;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  function automatic logic [35:0] rnd_data(input bit flag);
    logic [35:0] v;
    v[31:0]  = $urandom;
    v[33:32] = 2'($urandom);
    v[34]    = 1'($urandom);
    v[35]    = flag;
    return v;
  endfunction

  // per-clock comparison against the reference queue
  always @(negedge clk) begin
    out_ready = (rmode == 0) ? 1'b1 : lfsr[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    if (rst_n && start) chk(!out_valid && !in_ready, "R7 quiet during start", {in_ready, out_valid}, 0);
    if (rst_n && out_valid) begin
      chk(!in_ready, "R6 input held off while run pending", in_ready, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 sample beyond expected stream", out_sample, 0);
      end else begin
        chk(out_sample == exp_q[0], "R2 sample value", out_sample, exp_q[0]);
        if (out_ready) void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [35:0] e[$];
    bit prev;
    repeat (5) @(negedge clk);
    #1;
    chk(in_ready === 1'b1, "R8 reset in_ready", in_ready, 1);
    chk(out_valid === 1'b0, "R8 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: distinct high nibbles per entry position, no length words
    do_start(32'hFFFF_FFFF);
    e.delete();
    for (int i = 0; i < 8; i++) e.push_back({1'b0, 1'(i & 1), 2'(i >> 1), 32'h1000_0000 + 32'(i)});
    for (int i = 0; i < 16; i++) e.push_back(rnd_data(1'b0));
    send_entries(e);
    wait_drain("R1 nibble lanes drained");

    // R3 R4: random length words, flag on entry 7 crossing a slice, back-pressure
    rmode = 1;
    e.delete();
    prev = 0;
    for (int i = 0; i < 32; i++) begin
      if (prev) begin
        e.push_back(36'($urandom % 7));
        prev = 0;
      end else begin
        e.push_back(rnd_data((i == 7) || (i != 31 && ($urandom % 3 == 0))));
        prev = e[i][35];
      end
    end
    send_entries(e);
    wait_drain("R3 R4 length words under back-pressure");

    // R3: length 0 keeps only the inline run
    rmode = 0;
    e.delete();
    for (int i = 0; i < 4; i++) begin
      e.push_back(rnd_data(1'b1));
      e.push_back(36'd0);
    end
    send_entries(e);
    wait_drain("R3 zero length word");

    // R5: huge run cut off at the limit, rest of input still taken
    do_start(32'd13);
    e.delete();
    e.push_back(rnd_data(1'b1));
    e.push_back(36'h1_0000_0000);
    for (int i = 0; i < 14; i++) e.push_back(rnd_data(1'b0));
    send_entries(e);
    wait_drain("R5 limit of 13");
    chk(m_emitted == 13, "R5 model count", m_emitted, 13);
    #1;
    chk(in_ready && !out_valid, "R5 input flows after limit", {in_ready, out_valid}, 2'b10);

    // R5: limit of zero
    do_start(32'd0);
    e.delete();
    for (int i = 0; i < 8; i++) e.push_back(rnd_data(1'b0));
    send_entries(e);
    wait_drain("R5 limit of zero");

    // R7: start lands during a 41-sample run with out_ready high
    do_start(32'hFFFF_FFFF);
    e.delete();
    e.push_back(rnd_data(1'b1));
    e.push_back(36'd20);
    for (int i = 0; i < 6; i++) e.push_back(rnd_data(1'b0));
    e[0][34] = 1'b0;
    send_entries(e);
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid, "R7 run active before start", out_valid, 1);
    do_start(32'hFFFF_FFFF);
    #1;
    chk(!out_valid, "R7 run cleared after start", out_valid, 0);

    // R7: partly gathered slice and pending length state discarded
    e.delete();
    for (int i = 0; i < 7; i++) e.push_back(rnd_data(1'b0));
    e.push_back(rnd_data(1'b1));
    send_entries(e);
    wait_drain("R7 stream ending in length state");
    for (int i = 0; i < 4; i++) send_word($urandom);
    @(negedge clk);
    in_valid = 1'b0;
    do_start(32'hFFFF_FFFF);
    e.delete();
    for (int i = 0; i < 16; i++) e.push_back(rnd_data(1'b0));
    send_entries(e);
    wait_drain("R7 fresh decode after start");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule